// File: doc/BRIEF.md
# Load/Store Address Generator

This block sits beside the execute stage of a processor core. For single-register load and store instructions, it works out the memory address, the access size, whether the base register is written back, and the new base value. Given the instruction word, the fetch address of that instruction and two register-file read values, it produces these results combinationally in the same cycle.

Two offset encodings are supported. The word/byte form carries either a 12-bit unsigned immediate or a register shifted by an immediate amount. The halfword form carries either an 8-bit immediate split across two nibbles or a plain register. The offset can be added or subtracted. It is applied either before the access (pre-indexed) or only to the written-back base (post-indexed).

When memory returns read data, a single register stage formats it for the register file. This stage zero-extends or sign-extends bytes and halfwords according to the instruction presented in that cycle.

Top module: `lsu_agen`

## Requirements
- R1: Bit 26 set selects the word/byte form, where bit 22 set means byte (size_o=0) and clear means word (size_o=2). Bit 26 clear selects the halfword form, where bit 5 set means halfword (size_o=1) and clear means byte (size_o=0). is_load_o equals bit 20.
- R2: In the word/byte form with bit 25 clear, the offset magnitude is bits 11:0, zero-extended.
- R3: In the word/byte form with bit 25 set, the offset magnitude is the offset register value shifted by the amount in bits 11:7. The kind of shift comes from bits 6:5: 0 is left logical, 1 is right logical, 2 is right arithmetic and 3 is rotate right. An amount of 0 leaves the value unchanged.
- R4: In the halfword form, bit 22 set gives an offset of {bits 11:8, bits 3:0}, and bit 22 clear gives the offset register value unmodified.
- R5: When bit 23 is clear, the offset is negated (two's complement) before use. When bit 23 is set, it is added.
- R6: With bit 24 set, addr_o is base plus the signed offset. With bit 24 clear, addr_o is the base unchanged.
- R7: wb_base_o is always base plus the signed offset. wb_en_o is low only when bit 24 is set and bit 21 is clear.
- R8: If bits 19:16 equal 15, the base value used is pc_i+8 instead of base_i. If a register offset form has bits 3:0 equal to 15, the offset register value used is pc_i+8 instead of offs_reg_i.
- R9: load_valid_o is high in the cycle after a cycle with rdata_valid_i high, and low otherwise. When rdata_valid_i is low, load_data_o holds its value. Both outputs reset to 0.
- R10: The captured result depends on the form and size. A word-form word passes through unchanged. A word-form byte is rdata_i[7:0] zero-extended. A halfword is rdata_i[15:0], sign-extended when bit 6 is set and zero-extended otherwise. A halfword-form byte is rdata_i[7:0] sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Load/store instruction word |
| pc_i | input | 32 | Address of the instruction |
| base_i | input | 32 | Base register read value |
| offs_reg_i | input | 32 | Offset register read value |
| rdata_i | input | 32 | Raw memory read data |
| rdata_valid_i | input | 1 | Read data valid this cycle |
| addr_o | output | 32 | Effective access address |
| size_o | output | 2 | 0 byte, 1 halfword, 2 word |
| is_load_o | output | 1 | 1 load, 0 store |
| wb_en_o | output | 1 | Base writeback enable |
| wb_base_o | output | 32 | New base value |
| load_data_o | output | 32 | Formatted load result |
| load_valid_o | output | 1 | Formatted result valid |

## Verification
Two things can happen in the same cycle: the address and writeback results for a new instruction, and the formatting of read data that arrives alongside that instruction. The formatting follows the size and sign bits of that same instruction. The bench raises rdata_valid_i in most cycles while it changes the instruction form and size each cycle. It checks the combinational address, size and writeback in that cycle, and the registered load result one cycle later, each against a behavioural model. Pre-indexed forms with writeback are also covered, where the address and the new base must agree.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned PC_AHEAD = 8;
  localparam int unsigned REG_PC   = 15;

  // instruction bit positions that decide behaviour
  localparam int unsigned B_FORM   = 26;
  localparam int unsigned B_REGOFF = 25;
  localparam int unsigned B_PRE    = 24;
  localparam int unsigned B_UP     = 23;
  localparam int unsigned B_SZIMM  = 22;
  localparam int unsigned B_WBACK  = 21;
  localparam int unsigned B_LOAD   = 20;
  localparam int unsigned B_SIGN   = 6;
  localparam int unsigned B_HALF   = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/lsu_shift_imm.sv
module lsu_shift_imm
  import lsu_agen_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  shift_kind_e   kind_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  val_o
);
  logic [2*W-1:0] dbl;

  always_comb begin
    dbl = {val_i, val_i} >> amt_i;
    unique case (kind_i)
      SH_LSL:  val_o = val_i << amt_i;
      SH_LSR:  val_o = val_i >> amt_i;
      SH_ASR:  val_o = W'($signed(val_i) >>> amt_i);
      default: val_o = dbl[W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_offset_gen.sv
module lsu_offset_gen
  import lsu_agen_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned IMM_W  = 12,
  parameter int unsigned SH_POS = 7,
  localparam int unsigned AW    = $clog2(W)
) (
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] reg_val_i,
  output logic [W-1:0] off_mag_o
);
  logic [W-1:0] shifted;
  logic [W-1:0] wb_off, hw_off;

  lsu_shift_imm #(.W(W)) u_shift (
    .val_i  (reg_val_i),
    .kind_i (shift_kind_e'(instr_i[6:5])),
    .amt_i  (instr_i[SH_POS +: AW]),
    .val_o  (shifted)
  );

  always_comb begin
    wb_off = instr_i[B_REGOFF] ? shifted : W'(instr_i[IMM_W-1:0]);
    hw_off = instr_i[B_SZIMM]  ? W'({instr_i[11:8], instr_i[3:0]}) : reg_val_i;
    off_mag_o = instr_i[B_FORM] ? wb_off : hw_off;
  end
endmodule

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] off_mag_i,
  input  logic         up_i,
  input  logic         pre_i,
  input  logic         wback_i,
  output logic [W-1:0] addr_o,
  output logic         wb_en_o,
  output logic [W-1:0] wb_base_o
);
  logic [W-1:0] off_s;

  always_comb begin
    off_s     = up_i ? off_mag_i : (~off_mag_i + W'(1));
    wb_base_o = base_i + off_s;
    addr_o    = pre_i ? wb_base_o : base_i;
    wb_en_o   = !(pre_i && !wback_i);
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_agen_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] rdata_i,
  input  acc_size_e    size_i,
  input  logic         sext_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  logic [W-1:0] fmt;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: fmt = sext_i ? {{(W-8){rdata_i[7]}}, rdata_i[7:0]}
                            : {{(W-8){1'b0}}, rdata_i[7:0]};
      SZ_HALF: fmt = sext_i ? {{(W-16){rdata_i[15]}}, rdata_i[15:0]}
                            : {{(W-16){1'b0}}, rdata_i[15:0]};
      default: fmt = rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= fmt;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_data_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  a_r10_half_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sext_i && size_i == SZ_HALF) |=> data_o[W-1:16] == {(W-16){data_o[15]}});
  a_r10_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sext_i && size_i == SZ_BYTE) |=> data_o[W-1:8] == '0);
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_agen_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] base_i,
  input  logic [31:0] offs_reg_i,
  input  logic [31:0] rdata_i,
  input  logic        rdata_valid_i,
  output logic [31:0] addr_o,
  output logic [1:0]  size_o,
  output logic        is_load_o,
  output logic        wb_en_o,
  output logic [31:0] wb_base_o,
  output logic [31:0] load_data_o,
  output logic        load_valid_o
);
  localparam int unsigned W = XLEN;

  logic [W-1:0] pc_ahead, base_eff, offr_eff, off_mag;
  acc_size_e    size;
  logic         sext;

  assign pc_ahead = pc_i + W'(PC_AHEAD);
  assign base_eff = (instr_i[19:16] == 4'(REG_PC)) ? pc_ahead : base_i;
  assign offr_eff = (instr_i[3:0]   == 4'(REG_PC)) ? pc_ahead : offs_reg_i;

  always_comb begin
    if (instr_i[B_FORM]) begin
      size = instr_i[B_SZIMM] ? SZ_BYTE : SZ_WORD;
      sext = 1'b0;
    end else begin
      size = instr_i[B_HALF] ? SZ_HALF : SZ_BYTE;
      sext = instr_i[B_HALF] ? instr_i[B_SIGN] : 1'b1;
    end
  end

  assign size_o    = size;
  assign is_load_o = instr_i[B_LOAD];

  lsu_offset_gen #(.W(W)) u_offs (
    .instr_i   (instr_i),
    .reg_val_i (offr_eff),
    .off_mag_o (off_mag)
  );

  lsu_addr_calc #(.W(W)) u_addr (
    .base_i    (base_eff),
    .off_mag_i (off_mag),
    .up_i      (instr_i[B_UP]),
    .pre_i     (instr_i[B_PRE]),
    .wback_i   (instr_i[B_WBACK]),
    .addr_o    (addr_o),
    .wb_en_o   (wb_en_o),
    .wb_base_o (wb_base_o)
  );

  lsu_load_fmt #(.W(W)) u_fmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rdata_valid_i),
    .rdata_i (rdata_i),
    .size_i  (size),
    .sext_i  (sext),
    .data_o  (load_data_o),
    .valid_o (load_valid_o)
  );

  a_r6_post_uses_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_i[B_PRE] |-> addr_o == base_eff);
  a_r6_pre_matches_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[B_PRE] |-> addr_o == wb_base_o);
  a_r7_post_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_i[B_PRE] |-> wb_en_o);
  a_r5_zero_off_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_mag == '0) |-> wb_base_o == base_eff);
  a_r1_size_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o != 2'd3);
endmodule

// File: tb/tb_lsu_agen.sv
module tb_lsu_agen;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] instr = 0, pc = 0, base = 0, offr = 0, rdata = 0;
  logic        rv = 0;
  logic [31:0] addr, wb_base, ld_data;
  logic [1:0]  size;
  logic        is_load, wb_en, ld_valid;

  int checks = 0, errors = 0;
  logic [31:0] exp_ld = 0;
  logic        exp_lv = 0;

  always #(CLK_P/2) clk = ~clk;

  lsu_agen dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .pc_i(pc), .base_i(base),
    .offs_reg_i(offr), .rdata_i(rdata), .rdata_valid_i(rv),
    .addr_o(addr), .size_o(size), .is_load_o(is_load), .wb_en_o(wb_en),
    .wb_base_o(wb_base), .load_data_o(ld_data), .load_valid_o(ld_valid)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wb_ins(bit i, bit p, bit u, bit b, bit w, bit l,
                                         logic [3:0] rn, logic [11:0] low);
    return {4'hE, 2'b01, i, p, u, b, w, l, rn, 4'h1, low};
  endfunction

  function automatic logic [31:0] hw_ins(bit p, bit u, bit im, bit w, bit l, logic [3:0] rn,
                                         logic [3:0] hi, bit s, bit h, logic [3:0] lo);
    return {4'hE, 3'b000, p, u, im, w, l, rn, 4'h1, hi, 1'b1, s, h, 1'b1, lo};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [31:0] pcv, input logic [31:0] bv,
                       input logic [31:0] ov, output logic [31:0] a, output logic [31:0] wv,
                       output logic we, output logic [1:0] sz);
    logic [31:0] b, r, off;
    int amt;
    b = (ins[19:16] == 4'd15) ? pcv + 8 : bv;
    r = (ins[3:0] == 4'd15) ? pcv + 8 : ov;
    if (ins[26]) begin
      sz = ins[22] ? 2'd0 : 2'd2;
      if (!ins[25]) off = {20'd0, ins[11:0]};
      else begin
        amt = int'(ins[11:7]);
        case (ins[6:5])
          2'd0: off = r << amt;
          2'd1: off = r >> amt;
          2'd2: off = $signed(r) >>> amt;
          default: off = (amt == 0) ? r : ((r >> amt) | (r << (32 - amt)));
        endcase
      end
    end else begin
      sz  = ins[5] ? 2'd1 : 2'd0;
      off = ins[22] ? {24'd0, ins[11:8], ins[3:0]} : r;
    end
    if (!ins[23]) off = 32'd0 - off;
    wv = b + off;
    a  = ins[24] ? wv : b;
    we = !(ins[24] && !ins[21]);
  endtask

  function automatic logic [31:0] fmt(logic [31:0] ins, logic [31:0] d);
    if (ins[26]) return ins[22] ? {24'd0, d[7:0]} : d;
    if (ins[5])  return ins[6] ? {{16{d[15]}}, d[15:0]} : {16'd0, d[15:0]};
    return {{24{d[7]}}, d[7:0]};
  endfunction

  // one cycle: check last registered result, apply new inputs, check combinational results
  task automatic step(string req, logic [31:0] ins, logic [31:0] pcv, logic [31:0] bv,
                      logic [31:0] ov, logic [31:0] rd, logic v);
    logic [31:0] ea, ew;
    logic ee;
    logic [1:0] es;
    check("R9", "load_valid", {31'd0, ld_valid}, {31'd0, exp_lv});
    check("R10", "load_data", ld_data, exp_ld);
    instr = ins; pc = pcv; base = bv; offr = ov; rdata = rd; rv = v;
    #1;
    model(ins, pcv, bv, ov, ea, ew, ee, es);
    check(req, "addr", addr, ea);
    check(req, "wb_base", wb_base, ew);
    check("R7", "wb_en", {31'd0, wb_en}, {31'd0, ee});
    check("R1", "size", {30'd0, size}, {30'd0, es});
    check("R1", "is_load", {31'd0, is_load}, {31'd0, ins[20]});
    exp_lv = v;
    if (v) exp_ld = fmt(ins, rd);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset load_valid", {31'd0, ld_valid}, 32'd0);
    check("R9", "reset load_data", ld_data, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R2 immediate, pre-indexed, writeback, word load
    step("R2", wb_ins(0,1,1,0,1,1,4'd2,12'h024), 32'h100, 32'h1000, 0, 32'hDEADBEEF, 1);
    // R5 negative post-indexed byte store
    step("R5", wb_ins(0,0,0,1,0,0,4'd2,12'h010), 32'h100, 32'h2000, 0, 32'h0, 0);
    // R7 pre-indexed without writeback, byte load zero-extended
    step("R7", wb_ins(0,1,1,1,0,1,4'd4,12'hFFF), 32'h100, 32'h3000, 0, 32'hABCDEF80, 1);
    // R3 shift kinds
    step("R3", wb_ins(1,1,1,0,0,1,4'd2,{5'd2,2'd0,1'b0,4'd3}), 0, 32'h40, 32'd3, 32'h1, 1);
    step("R3", wb_ins(1,1,1,0,1,1,4'd2,{5'd4,2'd1,1'b0,4'd3}), 0, 32'h40, 32'h80000000, 32'h2, 1);
    step("R3", wb_ins(1,1,0,0,1,1,4'd2,{5'd4,2'd2,1'b0,4'd3}), 0, 32'h40, 32'h80000000, 32'h3, 0);
    step("R3", wb_ins(1,0,1,0,0,0,4'd2,{5'd8,2'd3,1'b0,4'd3}), 0, 32'h40, 32'h12345678, 32'h4, 1);
    step("R3", wb_ins(1,1,1,0,1,1,4'd2,{5'd0,2'd2,1'b0,4'd3}), 0, 32'h40, 32'h80000001, 32'h5, 1);
    step("R3", wb_ins(1,1,1,0,1,1,4'd2,{5'd31,2'd3,1'b0,4'd3}), 0, 32'h40, 32'h80000001, 32'h6, 1);
    // R8 base and offset register read as pc+8
    step("R8", wb_ins(0,1,1,0,0,1,4'd15,12'h004), 32'h400, 32'hBAD0BAD0, 0, 32'h7, 1);
    step("R8", wb_ins(1,1,1,0,1,1,4'd15,{5'd1,2'd0,1'b0,4'd15}), 32'h800, 32'h1, 32'h2, 32'h8, 1);
    // R4 split immediate, signed halfword load (R10)
    step("R4", hw_ins(1,1,1,1,1,4'd5,4'hA,1,1,4'h5), 0, 32'h5000, 0, 32'h00008001, 1);
    step("R4", hw_ins(0,0,1,0,1,4'd5,4'h0,0,1,4'hF), 0, 32'h5000, 0, 32'h12348001, 1);
    // R4 register form, post-indexed; offset index 15 uses pc+8 (R8)
    step("R4", hw_ins(0,1,0,0,1,4'd6,4'h0,1,0,4'd7), 0, 32'h6000, 32'h30, 32'h00000080, 1);
    step("R8", hw_ins(1,0,0,1,1,4'd6,4'h0,1,1,4'd15), 32'h20, 32'h6000, 32'h30, 32'h0000FFFE, 1);
    // R9 idle cycle: data must hold
    step("R9", hw_ins(1,1,1,0,0,4'd6,4'h1,0,1,4'h1), 0, 32'h7000, 0, 32'hFFFFFFFF, 0);
    step("R9", wb_ins(0,1,1,0,0,1,4'd1,12'h001), 0, 32'h0, 0, 32'h11223344, 1);
    // R10 byte and halfword variants back to back
    step("R10", hw_ins(1,1,1,0,1,4'd1,4'h0,1,0,4'h0), 0, 32'h10, 0, 32'h0000007F, 1);
    step("R10", hw_ins(1,1,1,0,1,4'd1,4'h0,0,1,4'h0), 0, 32'h10, 0, 32'hFFFF7FFF, 1);
    step("R10", wb_ins(0,1,1,1,0,1,4'd1,12'h000), 0, 32'h10, 0, 32'h000000FF, 1);
    step("R9", wb_ins(0,1,1,0,0,0,4'd1,12'h000), 0, 32'h10, 0, 32'h0, 0);
    check("R9", "final load_valid", {31'd0, ld_valid}, {31'd0, exp_lv});
    check("R10", "final load_data", ld_data, exp_ld);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule